// File: doc/BRIEF.md
# Dual Digital Phase Detector

This block holds two phase comparators that share one reference input. The first is an exclusive-OR comparator. Its output is high while the reference and a first comparison input are at different levels. The second is an edge-triggered set/reset comparator. A falling edge on the reference sets its output, and a falling edge on a second comparison input clears it. Rising edges do nothing to it. All three inputs are asynchronous. Each passes through a synchronizer into the system clock domain, and edges are found by comparing successive synchronized samples. Both comparator outputs are registered.

The block is meant to feed the up/down control of a loop counter in a fully digital phase-locked loop. At zero phase error each output is a square wave with 50% duty cycle. This needs a quarter-cycle lag between the exclusive-OR inputs and a half-cycle lag between the edge-triggered inputs. A built-in duty meter counts how many clock cycles each output was high over a fixed window of clock cycles. It reports both counts with a one-cycle valid strobe at the end of every window, so that the transfer curve can be checked directly.

Top module: `dual_phase_det`

## Requirements
- R1: An active-high synchronous reset drives `xor_out`, `edge_out` and `duty_valid` low on the next clock edge, empties the synchronizers and restarts the measurement window.
- R2: A level applied to any input before clock edge k reaches the comparator outputs at edge k+2. After edge k+1 the outputs still show the old value.
- R3: `xor_out` is 1 when `ref_in` and `cmp_xor_in` are at different synchronized levels and 0 when they are equal. It holds its value while neither synchronized input changes.
- R4: A falling edge of `ref_in` with no falling edge of `cmp_edge_in` in the same sample sets `edge_out` to 1.
- R5: A falling edge of `cmp_edge_in` with no falling edge of `ref_in` in the same sample clears `edge_out` to 0.
- R6: Rising edges on `ref_in` or `cmp_edge_in` leave `edge_out` unchanged.
- R7: When both falling edges are detected in the same sample, `edge_out` keeps its previous value.
- R8: Every WINDOW cycles, `duty_valid` is high for exactly one cycle. `duty_xor` and `duty_edge` then hold the number of cycles in that window during which `xor_out` and `edge_out` were high (0 to WINDOW).
- R9: With inputs of period P and 50% duty cycle, a lag of P/4 of `cmp_xor_in` behind `ref_in` gives `xor_out` a 50% duty cycle. A lag of P/2 of `cmp_edge_in` gives `edge_out` a 50% duty cycle.
- R10: For a lag of d cycles (0 <= d <= P/2), `xor_out` is high 2d out of every P cycles. It is always low at d=0 and always high at d=P/2. For a lag of d cycles (0 < d < P), `edge_out` is high d out of every P cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_in | input | 1 | Shared reference input (asynchronous) |
| cmp_xor_in | input | 1 | Comparison input of the exclusive-OR comparator (asynchronous) |
| cmp_edge_in | input | 1 | Comparison input of the edge-triggered comparator (asynchronous) |
| xor_out | output | 1 | Registered exclusive-OR comparator output |
| edge_out | output | 1 | Registered edge-triggered comparator output |
| duty_valid | output | 1 | One-cycle strobe at the end of each measurement window |
| duty_xor | output | $clog2(WINDOW+1) | High-cycle count of `xor_out` over the last window |
| duty_edge | output | $clog2(WINDOW+1) | High-cycle count of `edge_out` over the last window |

## Verification
The assertions assume that every input level lasts at least two clock cycles, so that each transition appears in the synchronized sample stream as exactly one edge. They also assume that reset is held long enough to flush the synchronizer chains. The stimulus changes inputs only on falling clock edges. It holds each directed level for three cycles, and it generates periodic waveforms with a 16-cycle period, which divides the 64-cycle window. A measurement is taken only after two whole windows have passed under a new lag setting, so that each expected duty count is exact.

// File: rtl/pd_pkg.sv
package pd_pkg;
  // Positions of the asynchronous lines inside the synchronizer bundle
  localparam int PD_NLINES = 3;
  localparam int PD_REF    = 0;
  localparam int PD_CMPX   = 1;
  localparam int PD_CMPE   = 2;
  // Channels watched by the duty meter
  localparam int PD_NCH    = 2;
  localparam int PD_CH_XOR = 0;
  localparam int PD_CH_EDG = 1;
endpackage

// File: rtl/pd_sync.sv
module pd_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-2:0], async_in[i]};
    end
    assign sync_out[i] = chain[STAGES-1];
  end
endmodule

// File: rtl/pd_xor_det.sv
module pd_xor_det (
  input  logic clk,
  input  logic rst,
  input  logic a,
  input  logic b,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= a ^ b;
  end

  // R3
  xor_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ($stable(a) && $stable(b)) |=> $stable(q));
endmodule

// File: rtl/pd_edge_det.sv
module pd_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic set_line,
  input  logic clr_line,
  output logic q
);
  logic prev_set, prev_clr;
  logic set_fall, clr_fall;

  assign set_fall = prev_set & ~set_line;
  assign clr_fall = prev_clr & ~clr_line;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_set <= 1'b0;
      prev_clr <= 1'b0;
      q        <= 1'b0;
    end else begin
      prev_set <= set_line;
      prev_clr <= clr_line;
      if (set_fall && !clr_fall)      q <= 1'b1;
      else if (clr_fall && !set_fall) q <= 1'b0;
    end
  end

  // R4
  set_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (set_fall && !clr_fall) |=> q);
  // R5
  clr_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_fall && !set_fall) |=> !q);
  // R6
  rise_no_effect_chk: assert property (@(posedge clk) disable iff (rst)
    (!set_fall && !clr_fall) |=> $stable(q));
  // R7
  both_fall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (set_fall && clr_fall) |=> $stable(q));
endmodule

// File: rtl/pd_duty_meter.sv
module pd_duty_meter #(
  parameter int NCH    = 2,
  parameter int WINDOW = 64,
  localparam int TW    = (WINDOW > 2) ? $clog2(WINDOW) : 1,
  localparam int CW    = $clog2(WINDOW + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NCH-1:0]          sig,
  output logic                    valid,
  output logic [NCH-1:0][CW-1:0]  count
);
  localparam logic [TW-1:0] LAST = TW'(WINDOW - 1);

  logic [TW-1:0] tick;
  logic          wrap;

  assign wrap = (tick == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      tick  <= '0;
      valid <= 1'b0;
    end else begin
      tick  <= wrap ? '0 : tick + 1'b1;
      valid <= wrap;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [CW-1:0] acc;
    logic [CW-1:0] acc_next;
    assign acc_next = acc + {{(CW-1){1'b0}}, sig[c]};
    always_ff @(posedge clk) begin
      if (rst) begin
        acc      <= '0;
        count[c] <= '0;
      end else if (wrap) begin
        acc      <= '0;
        count[c] <= acc_next;
      end else begin
        acc      <= acc_next;
      end
    end

    // R8
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
      valid |-> (count[c] <= CW'(WINDOW)));
  end

  // R8
  valid_single_chk: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);
endmodule

// File: rtl/dual_phase_det.sv
module dual_phase_det
  import pd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int WINDOW      = 64,
  localparam int CW         = $clog2(WINDOW + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ref_in,
  input  logic          cmp_xor_in,
  input  logic          cmp_edge_in,
  output logic          xor_out,
  output logic          edge_out,
  output logic          duty_valid,
  output logic [CW-1:0] duty_xor,
  output logic [CW-1:0] duty_edge
);
  logic [PD_NLINES-1:0]       raw_lines, sync_lines;
  logic [PD_NCH-1:0]          watched;
  logic [PD_NCH-1:0][CW-1:0]  counts;

  always_comb begin
    raw_lines          = '0;
    raw_lines[PD_REF]  = ref_in;
    raw_lines[PD_CMPX] = cmp_xor_in;
    raw_lines[PD_CMPE] = cmp_edge_in;
  end

  pd_sync #(.WIDTH(PD_NLINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(raw_lines), .sync_out(sync_lines)
  );

  pd_xor_det u_xor (
    .clk(clk), .rst(rst),
    .a(sync_lines[PD_REF]), .b(sync_lines[PD_CMPX]), .q(xor_out)
  );

  pd_edge_det u_edge (
    .clk(clk), .rst(rst),
    .set_line(sync_lines[PD_REF]), .clr_line(sync_lines[PD_CMPE]), .q(edge_out)
  );

  always_comb begin
    watched            = '0;
    watched[PD_CH_XOR] = xor_out;
    watched[PD_CH_EDG] = edge_out;
  end

  pd_duty_meter #(.NCH(PD_NCH), .WINDOW(WINDOW)) u_meter (
    .clk(clk), .rst(rst), .sig(watched), .valid(duty_valid), .count(counts)
  );

  assign duty_xor  = counts[PD_CH_XOR];
  assign duty_edge = counts[PD_CH_EDG];

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!xor_out && !edge_out && !duty_valid));
endmodule

// File: tb/dual_phase_det_test.sv
`timescale 1ns/1ps
module dual_phase_det_test;
  localparam int WIN = 64;
  localparam int PER = 16;
  localparam int CW  = $clog2(WIN + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_in = 1'b0, cmp_xor_in = 1'b0, cmp_edge_in = 1'b0;
  logic xor_out, edge_out, duty_valid;
  logic [CW-1:0] duty_xor, duty_edge;

  int n_tests = 0;
  int n_fail  = 0;

  bit gen_en = 1'b0;
  int lag_x  = 0;
  int lag_e  = 0;
  int ph     = 0;

  typedef struct {
    int    exp_x;
    int    exp_e;
    string tag;
  } sb_item_t;
  sb_item_t sb_q[$];

  dual_phase_det #(.SYNC_STAGES(2), .WINDOW(WIN)) uut (
    .clk(clk), .rst(rst), .ref_in(ref_in), .cmp_xor_in(cmp_xor_in),
    .cmp_edge_in(cmp_edge_in), .xor_out(xor_out), .edge_out(edge_out),
    .duty_valid(duty_valid), .duty_xor(duty_xor), .duty_edge(duty_edge)
  );

  always #4 clk = ~clk;

  task automatic check(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  // waveform generator: ref high for the first half of each period, comparisons lag it
  initial begin
    forever begin
      @(negedge clk);
      if (gen_en) begin
        ph          = (ph + 1) % PER;
        ref_in      = (ph < PER / 2);
        cmp_xor_in  = (((ph + PER - lag_x) % PER) < PER / 2);
        cmp_edge_in = (((ph + PER - lag_e) % PER) < PER / 2);
      end
    end
  end

  // monitor: pop expected duty counts as windows complete
  initial begin
    forever begin
      @(negedge clk);
      if (duty_valid && sb_q.size() > 0) begin
        sb_item_t it;
        it = sb_q.pop_front();
        check({it.tag, " xor duty"},  int'(duty_xor),  it.exp_x);
        check({it.tag, " edge duty"}, int'(duty_edge), it.exp_e);
      end
    end
  end

  task automatic wait_valid();
    do @(negedge clk); while (!duty_valid);
  endtask

  // driver: apply a lag pair, let two windows pass, then queue the expectation
  task automatic run_lag(int lx, int le, int ex, int ee, string tag);
    lag_x  = lx;
    lag_e  = le;
    gen_en = 1'b1;
    wait_valid();
    wait_valid();
    @(negedge clk);
    sb_q.push_back('{ex, ee, tag});
    while (sb_q.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    step(4);
    check("R1 xor after reset",   int'(xor_out),    0);
    check("R1 edge after reset",  int'(edge_out),   0);
    check("R1 valid after reset", int'(duty_valid), 0);
    rst = 1'b0;

    // R3 / R6: ref rises while comparisons stay low
    ref_in = 1'b1;
    step(2);
    check("R2 xor not yet updated", int'(xor_out), 0);
    step(1);
    check("R3 xor differ", int'(xor_out), 1);
    check("R6 ref rise no set", int'(edge_out), 0);

    cmp_xor_in = 1'b1;
    step(3);
    check("R3 xor equal high", int'(xor_out), 0);

    // R4: ref falls
    ref_in = 1'b0;
    step(2);
    check("R2 edge not yet set", int'(edge_out), 0);
    step(1);
    check("R4 ref fall sets", int'(edge_out), 1);
    check("R3 xor differ low ref", int'(xor_out), 1);

    // R6: comparison rises
    cmp_edge_in = 1'b1;
    step(3);
    check("R6 cmp rise no clear", int'(edge_out), 1);

    // R5: comparison falls
    cmp_edge_in = 1'b0;
    step(3);
    check("R5 cmp fall clears", int'(edge_out), 0);

    // R7: set, raise both, then both fall together
    ref_in = 1'b1;
    step(3);
    ref_in = 1'b0;
    step(3);
    check("R4 set again", int'(edge_out), 1);
    ref_in = 1'b1;
    cmp_edge_in = 1'b1;
    step(3);
    check("R6 both rise hold", int'(edge_out), 1);
    ref_in = 1'b0;
    cmp_edge_in = 1'b0;
    step(3);
    check("R7 both fall hold high", int'(edge_out), 1);
    cmp_edge_in = 1'b1;
    step(3);
    cmp_edge_in = 1'b0;
    step(3);
    check("R5 clear after hold", int'(edge_out), 0);
    ref_in = 1'b1;
    cmp_edge_in = 1'b1;
    step(3);
    ref_in = 1'b0;
    cmp_edge_in = 1'b0;
    step(3);
    check("R7 both fall hold low", int'(edge_out), 0);

    // R1: reset in the middle of operation
    ref_in = 1'b1;
    step(3);
    ref_in = 1'b0;
    step(3);
    check("R4 set before reset", int'(edge_out), 1);
    rst = 1'b1;
    step(1);
    check("R1 mid reset edge", int'(edge_out), 0);
    check("R1 mid reset xor",  int'(xor_out),  0);
    step(2);
    rst = 1'b0;
    ref_in = 1'b0;
    cmp_xor_in = 1'b0;
    cmp_edge_in = 1'b0;
    ph = PER - 1;
    step(2);

    // duty measurements (R8 window counts)
    run_lag(0, 0, 0, 0, "R10/R7 zero lag");
    run_lag(PER / 4, PER / 2, WIN / 2, WIN / 2, "R9 R8 zero error");
    run_lag(PER / 2, 1, WIN, 4, "R10 limit");
    run_lag(2, 15, 16, 60, "R10 gain a");
    run_lag(6, 12, 48, 48, "R10 gain b");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule